// File: doc/BRIEF.md
# Addressed Serial Control Slave

This block is the command front end of a field output driver. A host shares one three-wire serial bus among up to eight such drivers. The bus has a serial clock, a data line and an active-low frame select. Each driver is told apart by three strap inputs. The block runs entirely on an oversampled system clock. It brings the three serial lines into that domain through synchronisers and finds their edges there. The serial clock idles high, and the system clock must run at least four times faster than it.

A write frame carries a 16-bit command, most-significant bit first. When the frame select returns high, a command whose address matches the straps is loaded into an 8-bit control register. That register holds the range code, clear select, output enable, software clear and current-sense select. A software reset bit in the command clears the register instead, and is never stored. A read frame with a matching address turns on the serial data output part-way through the frame. The output then shifts back the control fields and four status flags.

The frame engine is a four-state machine:
- `ST_IDLE`: waits for the frame select.
- `ST_RECV`: counts edges and shifts data in.
- `ST_DRIVE`: is the same, with the data output enabled.
- `ST_COMMIT`: lasts one cycle and decides whether the finished frame is applied.

It has five transitions:
- IDLE→RECV when the select goes low.
- RECV→DRIVE on the 5th serial rising edge of an addressed read.
- RECV→COMMIT when the select rises.
- DRIVE→COMMIT when the select rises.
- COMMIT→IDLE unconditionally.

Top module: `serial_ctl_slave`

## Requirements
- R1: Data is sampled on the falling serial-clock edge, MSB first. In a 16-bit write, bits 15..13 hold the address and bit 12 is the read flag (0 = write). The fields are range code in bits 10..7, clear select in bit 6, output enable in bit 5, software clear in bit 4, sense select in bit 3 and software reset in bit 2. They appear on `range_code`, `clr_sel`, `out_en`, `sw_clear` and `rsense_sel`.
- R2: A write changes the register only when bits 15..13 equal `strap_addr`; any other address leaves every output unchanged.
- R3: The control outputs do not change while a frame is in progress; a write takes effect only after `fsel_n` rises.
- R4: A frame is applied only when it held exactly 16 or 24 falling edges; a 24-edge frame uses its first 16 bits. Any other count leaves all state unchanged.
- R5: In an addressed read (bit 12 = 1), `sdo_oe` stays low through the 4th rising edge and goes high on the 5th. Rising edges 5..15 drive readback bits 10..0 on `sdo`. The readback fields are range code in bits 10..7, clear select in bit 6, output enable in bit 5, sense select in bit 4, over-temperature in bit 3, current fault in bit 2, voltage fault in bit 1 and checksum error in bit 0. Whenever `sdo_oe` is low, `sdo` is low.
- R6: After `fsel_n` rises, `sdo_oe` returns low, and a read frame leaves the control register unchanged.
- R7: While `rst_n` is low, every control output and `sdo_oe` is zero and frames are ignored.
- R8: A write with bit 2 set clears the whole control register whatever the other fields hold. The bit is not kept, so the next ordinary write applies normally.
- R9: A read whose address differs from the straps never enables `sdo`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low level reset |
| sclk | input | 1 | Serial clock, idles high |
| sdin | input | 1 | Serial data in |
| fsel_n | input | 1 | Active-low frame select; rising edge ends a frame |
| strap_addr | input | 3 | Device address straps |
| flt_temp | input | 1 | Over-temperature status |
| flt_iout | input | 1 | Current-output fault status |
| flt_vout | input | 1 | Voltage-output fault status |
| flt_crc | input | 1 | Checksum error status |
| sdo | output | 1 | Serial readback data |
| sdo_oe | output | 1 | Enable for the readback driver |
| range_code | output | 4 | Output range selection |
| clr_sel | output | 1 | Clear value select |
| out_en | output | 1 | Output enable |
| sw_clear | output | 1 | Software clear |
| rsense_sel | output | 1 | Current-sense resistor select |

## Verification
A wrong bit or edge count inside the frame engine cannot hide. It either mis-times the rise of `sdo_oe` or shifts the readback word by a bit position, and the bench sees this at the first sample point after the 5th rising edge. A bad length or address decision shows at the control outputs a few system clocks after `fsel_n` rises. A register that takes a value early shows up before the frame ends, because the bench compares the outputs against the old value just before the select rises. Reads sweep every status combination, so a swapped or stuck readback bit is caught within one read frame.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

    localparam int WORD_W   = 16;
    localparam int ALT_W    = 24;
    localparam int ADDR_W   = 3;
    localparam int RD_START = 5;

    localparam int P_ADDR_HI  = 15;
    localparam int P_RW       = 12;
    localparam int P_RANGE_HI = 10;
    localparam int P_RANGE_LO = 7;
    localparam int P_CLRSEL   = 6;
    localparam int P_OUTEN    = 5;
    localparam int P_SWCLR    = 4;
    localparam int P_RSENSE   = 3;
    localparam int P_SWRST    = 2;

    localparam int RB_TOP = 10;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RECV   = 2'd1,
        ST_DRIVE  = 2'd2,
        ST_COMMIT = 2'd3
    } fr_state_t;

    typedef struct packed {
        logic [3:0] range;
        logic       clr_sel;
        logic       out_en;
        logic       sw_clr;
        logic       rsense;
    } ctl_t;

endpackage

// File: rtl/sync_edge.sv
module sync_edge #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    logic [W-1:0] stg [STAGES];
    logic [W-1:0] prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
            prev <= RST_VAL;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            prev <= stg[STAGES-1];
        end
    end

    assign level = stg[STAGES-1];
    assign rise  = stg[STAGES-1] & ~prev;
    assign fall  = ~stg[STAGES-1] & prev;

endmodule

// File: rtl/frame_fsm.sv
module frame_fsm
    import sctl_pkg::*;
#(
    parameter int WW = WORD_W,
    parameter int AW = ALT_W,
    parameter int NA = ADDR_W,
    parameter int RS = RD_START
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_rise,
    input  logic          sclk_fall,
    input  logic          sdin_s,
    input  logic          fsel_lvl,
    input  logic          fsel_rise,
    input  logic [NA-1:0] strap,
    input  logic [WW-1:0] rb_word,
    output logic          commit,
    output logic [WW-1:0] cmd_word,
    output logic          sdo,
    output logic          sdo_oe
);

    localparam int CNT_W   = $clog2(AW + 2);
    localparam int CNT_MAX = (1 << CNT_W) - 1;
    localparam int RB_W    = RB_TOP + 1;

    fr_state_t       state, nxt;
    logic [CNT_W-1:0] fall_cnt, rise_cnt;
    logic [WW-1:0]   shift_q;
    logic [RB_W-1:0] rb_sh;
    logic            commit_q, sdo_q, oe_q;
    logic            rd_hit, len_ok, wr_hit;

    // address and read flag sit in the low bits after RS falling edges
    assign rd_hit = sclk_rise
                 && (rise_cnt == CNT_W'(RS - 1))
                 && (fall_cnt == CNT_W'(RS))
                 && (shift_q[RS-1 -: NA] == strap)
                 && shift_q[RS-1-NA];

    assign len_ok = (fall_cnt == CNT_W'(WW)) || (fall_cnt == CNT_W'(AW));
    assign wr_hit = len_ok
                 && (shift_q[P_ADDR_HI -: NA] == strap)
                 && !shift_q[P_RW];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (!fsel_lvl) nxt = ST_RECV;
            ST_RECV: begin
                if (fsel_rise)   nxt = ST_COMMIT;
                else if (rd_hit) nxt = ST_DRIVE;
            end
            ST_DRIVE:  if (fsel_rise) nxt = ST_COMMIT;
            ST_COMMIT: nxt = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fall_cnt <= '0;
            rise_cnt <= '0;
            shift_q  <= '0;
            rb_sh    <= '0;
            commit_q <= 1'b0;
            sdo_q    <= 1'b0;
            oe_q     <= 1'b0;
        end else begin
            commit_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    fall_cnt <= '0;
                    rise_cnt <= '0;
                    shift_q  <= '0;
                    sdo_q    <= 1'b0;
                    oe_q     <= 1'b0;
                end
                ST_RECV, ST_DRIVE: begin
                    if (sclk_fall) begin
                        if (fall_cnt != CNT_W'(CNT_MAX)) fall_cnt <= fall_cnt + 1'b1;
                        if (fall_cnt < CNT_W'(WW)) shift_q <= {shift_q[WW-2:0], sdin_s};
                    end
                    if (sclk_rise) begin
                        if (rise_cnt != CNT_W'(CNT_MAX)) rise_cnt <= rise_cnt + 1'b1;
                    end
                    if (state == ST_RECV && nxt == ST_DRIVE) begin
                        oe_q  <= 1'b1;
                        sdo_q <= rb_word[RB_TOP];
                        rb_sh <= {rb_word[RB_TOP-1:0], 1'b0};
                    end else if (state == ST_DRIVE && sclk_rise) begin
                        sdo_q <= rb_sh[RB_W-1];
                        rb_sh <= {rb_sh[RB_W-2:0], 1'b0};
                    end
                end
                ST_COMMIT: begin
                    commit_q <= wr_hit;
                    sdo_q    <= 1'b0;
                    oe_q     <= 1'b0;
                end
            endcase
        end
    end

    assign commit   = commit_q;
    assign cmd_word = shift_q;
    assign sdo      = sdo_q;
    assign sdo_oe   = oe_q;

    AST_SDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe |-> !sdo);  // R5
    AST_OE_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> ($past(fall_cnt) == CNT_W'(RS)) && ($past(shift_q[RS-1 -: NA]) == strap)); // R9
    AST_LEN_OK: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> ($past(fall_cnt) == CNT_W'(WW)) || ($past(fall_cnt) == CNT_W'(AW))); // R4

endmodule

// File: rtl/ctrl_reg.sv
module ctrl_reg
    import sctl_pkg::*;
#(
    parameter int WW = WORD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [WW-1:0] wdata,
    output ctl_t          ctl
);

    ctl_t ctl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_en) begin
            if (wdata[P_SWRST]) begin
                ctl_q <= '0;
            end else begin
                ctl_q.range   <= wdata[P_RANGE_HI:P_RANGE_LO];
                ctl_q.clr_sel <= wdata[P_CLRSEL];
                ctl_q.out_en  <= wdata[P_OUTEN];
                ctl_q.sw_clr  <= wdata[P_SWCLR];
                ctl_q.rsense  <= wdata[P_RSENSE];
            end
        end
    end

    assign ctl = ctl_q;

    AST_SWRST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata[P_SWRST]) |=> (ctl == '0)); // R8

endmodule

// File: rtl/serial_ctl_slave.sv
module serial_ctl_slave
    import sctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              sdin,
    input  logic              fsel_n,
    input  logic [ADDR_W-1:0] strap_addr,
    input  logic              flt_temp,
    input  logic              flt_iout,
    input  logic              flt_vout,
    input  logic              flt_crc,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [3:0]        range_code,
    output logic              clr_sel,
    output logic              out_en,
    output logic              sw_clear,
    output logic              rsense_sel
);

    logic [2:0]        s_lvl, s_rise, s_fall;
    logic              commit;
    logic [WORD_W-1:0] cmd_word, rb_word;
    ctl_t              ctl;

    // bit 2: serial clock, bit 1: data, bit 0: frame select
    sync_edge #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b101)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({sclk, sdin, fsel_n}),
        .level (s_lvl),
        .rise  (s_rise),
        .fall  (s_fall)
    );

    assign rb_word = {{(WORD_W-RB_TOP-1){1'b0}}, ctl.range, ctl.clr_sel, ctl.out_en,
                      ctl.rsense, flt_temp, flt_iout, flt_vout, flt_crc};

    frame_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (s_rise[2]),
        .sclk_fall (s_fall[2]),
        .sdin_s    (s_lvl[1]),
        .fsel_lvl  (s_lvl[0]),
        .fsel_rise (s_rise[0]),
        .strap     (strap_addr),
        .rb_word   (rb_word),
        .commit    (commit),
        .cmd_word  (cmd_word),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe)
    );

    ctrl_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (commit),
        .wdata (cmd_word),
        .ctl   (ctl)
    );

    assign range_code = ctl.range;
    assign clr_sel    = ctl.clr_sel;
    assign out_en     = ctl.out_en;
    assign sw_clear   = ctl.sw_clr;
    assign rsense_sel = ctl.rsense;

    AST_CTL_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctl) |-> $past(commit)); // R3
    AST_OE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> !s_lvl[0]); // R6

endmodule

// File: tb/sim_serial_ctl_slave.sv
module sim_serial_ctl_slave;

    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1, sdin = 1'b0, fsel_n = 1'b1;
    logic [2:0] strap = 3'b101;
    logic f_t = 0, f_i = 0, f_v = 0, f_c = 0;
    logic sdo, sdo_oe, clr_sel, out_en, sw_clear, rsense_sel;
    logic [3:0] range_code;

    int n_chk = 0, n_fail = 0;
    logic [7:0] exp_ctl = '0;  // {range, clr, oe, swclr, rsense}

    always #5 clk = ~clk;

    serial_ctl_slave u0 (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdin(sdin), .fsel_n(fsel_n),
        .strap_addr(strap), .flt_temp(f_t), .flt_iout(f_i), .flt_vout(f_v), .flt_crc(f_c),
        .sdo(sdo), .sdo_oe(sdo_oe), .range_code(range_code), .clr_sel(clr_sel),
        .out_en(out_en), .sw_clear(sw_clear), .rsense_sel(rsense_sel)
    );

    function automatic logic [7:0] act_ctl();
        return {range_code, clr_sel, out_en, sw_clear, rsense_sel};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] wr_word(input logic [2:0] a, input logic [3:0] r,
                                            input logic [3:0] f, input logic rst_bit);
        return {a, 1'b0, 1'b0, r, f, rst_bit, 2'b00};
    endfunction

    function automatic logic [7:0] model(input logic [15:0] w);
        if (w[2]) return 8'h00;
        return {w[10:7], w[6], w[5], w[4], w[3]};
    endfunction

    // mode 0: write/no sdo check, 1: expect readback, 2: expect sdo disabled
    task automatic frame(input logic [15:0] w, input int nbits, input int mode,
                         input logic [15:0] rb);
        fsel_n = 1'b0;
        wclk(HALF);
        for (int k = 1; k <= nbits; k++) begin
            sdin = (k <= 16) ? w[16-k] : 1'b0;
            wclk(HALF);
            if (mode == 1 && k == 5) chk("R5 oe low before 5th rise", sdo_oe, 0);
            if (mode == 1 && k >= 6 && k <= 16) begin
                chk("R5 oe high", sdo_oe, 1);
                chk("R5 readback bit", sdo, rb[16-k]);
            end
            if (mode == 2) chk("R9 oe stays low", sdo_oe, 0);
            sclk = 1'b0;
            wclk(HALF);
            sclk = 1'b1;
        end
        wclk(HALF);
        chk("R3 no change before strobe", act_ctl(), exp_ctl);
        fsel_n = 1'b1;
        wclk(12);
        sdin = 1'b0;
    endtask

    task automatic do_write(input logic [15:0] w, input int nbits, input string req);
        logic [7:0] nxt;
        nxt = exp_ctl;
        if ((nbits == 16 || nbits == 24) && w[15:13] == strap && !w[12]) nxt = model(w);
        frame(w, nbits, 0, 16'h0);
        exp_ctl = nxt;
        chk(req, act_ctl(), exp_ctl);
    endtask

    task automatic do_read(input logic [2:0] a);
        logic [15:0] rb;
        rb = {5'b0, exp_ctl[7:4], exp_ctl[3], exp_ctl[2], exp_ctl[0], f_t, f_i, f_v, f_c};
        frame({a, 1'b1, 12'h000}, 16, (a == strap) ? 1 : 2, rb);
        chk("R6 oe off after strobe", sdo_oe, 0);
        chk("R6 read keeps register", act_ctl(), exp_ctl);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        wclk(4);
        chk("R7 reset outputs", act_ctl(), 8'h00);
        chk("R7 reset oe", sdo_oe, 0);
        // frame while held in reset is ignored
        frame(wr_word(3'b101, 4'hF, 4'hF, 1'b0), 16, 0, 16'h0);
        chk("R7 frame ignored in reset", act_ctl(), 8'h00);
        rst_n = 1'b1;
        wclk(4);

        // R1: all range codes with varied flag fields
        for (int r = 0; r < 16; r++)
            do_write(wr_word(3'b101, 4'(r), 4'(r * 7 + 3), 1'b0), 16, "R1 field write");

        // R2: address sweep
        for (int a = 0; a < 8; a++)
            do_write(wr_word(3'(a), 4'(a + 1), 4'(15 - a), 1'b0), 16, "R2 address match");
        strap = 3'b010;
        do_write(wr_word(3'b010, 4'h9, 4'b1010, 1'b0), 16, "R2 new strap");
        do_write(wr_word(3'b101, 4'h3, 4'b0101, 1'b0), 16, "R2 old strap ignored");

        // R4: frame length sweep
        for (int n = 12; n <= 26; n++)
            do_write(wr_word(3'b010, 4'(n), 4'(n), 1'b0), n, "R4 frame length");

        // R5 / R6 / R9: readback over all status combinations
        for (int s = 0; s < 16; s++) begin
            {f_t, f_i, f_v, f_c} = 4'(s);
            if (s == 5) do_write(wr_word(3'b010, 4'hA, 4'b0110, 1'b0), 16, "R1 field write");
            do_read(3'b010);
        end
        do_read(3'b011);
        do_read(3'b110);

        // R8: software reset clears, then self-clears
        do_write(wr_word(3'b010, 4'hC, 4'b1111, 1'b0), 16, "R1 field write");
        do_write(wr_word(3'b010, 4'h7, 4'b1011, 1'b1), 16, "R8 software reset");
        do_write(wr_word(3'b010, 4'h6, 4'b1101, 1'b0), 16, "R8 write after reset");
        do_read(3'b010);

        // R7: level reset mid-operation
        rst_n = 1'b0;
        wclk(3);
        chk("R7 async reset clears", act_ctl(), 8'h00);
        wclk(20);
        chk("R7 held reset", act_ctl(), 8'h00);
        exp_ctl = '0;
        rst_n = 1'b1;
        wclk(4);
        do_write(wr_word(3'b010, 4'h1, 4'b0100, 1'b0), 16, "R7 works after reset");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule